// File: doc/BRIEF.md
# Cascadable Presettable Decade Counter

This block is one decimal digit of a synchronous counter. On each rising clock edge it either loads a four-bit value from its data input, steps through the sequence 0, 1, ... 9, 0, or keeps its value. An active-low clear input forces the digit to zero at once, without waiting for a clock edge. Two separate count enables gate stepping: a shared enable and a chain enable. Only the chain enable qualifies the terminal flag, and the flag rises while the digit shows 9.

Several stages form a multi-digit counter. All stages share the clock and the shared enable. The first stage has its chain enable tied high, and each later stage takes its chain enable from the terminal flag of the stage below it. Every digit changes on the same edge, so no carry ripples through registers. There is no data stream here: every pin is a plain level-sensitive control or status signal, and the block has no handshake and no back-pressure.

Top module: `bcd_decade_ctr`

## Requirements
- R1: With load_n_i high and both cnt_en_i and chain_en_i high, each rising edge advances count_o by one through 0..9, and 9 is followed by 0.
- R2: While clr_n_i is low, count_o is 0 within the same clock period, without a clock edge. This overrides the load, the enables and any clock edges that arrive while clear is held.
- R3: When load_n_i is low at a rising edge, count_o takes the value of din_i on that edge, whatever the levels of cnt_en_i and chain_en_i.
- R4: When load_n_i is high and either cnt_en_i or chain_en_i is low, count_o keeps its value across rising edges.
- R5: term_o is 1 exactly when chain_en_i is 1 and count_o equals 9. It is combinational, so it follows chain_en_i without a clock edge, and cnt_en_i has no effect on it.
- R6: A loaded value from 10 to 15 advances by one on each enabled edge, and 15 is followed by 0, so the digit returns to the 0..9 range.
- R7: Three stages chained through term_o and chain_en_i, with a shared cnt_en_i, count as one three-digit decimal value from 000 to 999 and then roll over to 000. When the shared enable is low, all three digits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| clr_n_i | input | 1 | Asynchronous clear, active low |
| load_n_i | input | 1 | Synchronous parallel load, active low |
| din_i | input | 4 | Value taken on a load |
| cnt_en_i | input | 1 | Shared count enable |
| chain_en_i | input | 1 | Chain count enable; also qualifies term_o |
| count_o | output | 4 | Current digit value |
| term_o | output | 1 | Terminal flag: chain_en_i high and digit at 9 |

## Verification
The clocked properties treat the clear as asynchronous. They stay inactive at any edge where clear is low, and at the first edge after a clear, because the state at the previous edge was forced and not computed. They also assume that the inputs are stable around each rising edge. The bench therefore changes every input, clear included, 1 ns after a rising edge, which keeps all changes well away from the next edge. The clear-overrides-clock behaviour is covered by holding clear low across an edge while load and both enables are active.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

  // Action selected for the digit register at the next rising edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } ctr_op_e;

endpackage

// File: rtl/bcd_ctr_ctrl.sv
module bcd_ctr_ctrl
  import bcd_ctr_pkg::*;
(
  input  logic    load_n_i,
  input  logic    cnt_en_i,
  input  logic    chain_en_i,
  output ctr_op_e op_o
);

  // Load wins over both enables; stepping needs both enables high
  always_comb begin
    if (!load_n_i)                    op_o = OP_LOAD;
    else if (cnt_en_i && chain_en_i)  op_o = OP_STEP;
    else                              op_o = OP_HOLD;
  end

endmodule

// File: rtl/bcd_ctr_next.sv
module bcd_ctr_next
  import bcd_ctr_pkg::*;
#(
  parameter int DIG_W    = 4,
  parameter int LAST_VAL = 9
) (
  input  ctr_op_e            op_i,
  input  logic [DIG_W-1:0]   cur_i,
  input  logic [DIG_W-1:0]   din_i,
  output logic [DIG_W-1:0]   nxt_o
);

  localparam logic [DIG_W-1:0] LAST_V = DIG_W'(LAST_VAL);
  localparam logic [DIG_W-1:0] ONE_V  = DIG_W'(1);

  logic [DIG_W-1:0] stepped;

  // The wrap happens at the last decimal value. A code above it carries on
  // upward and wraps naturally at the top of the binary range.
  always_comb begin
    if (cur_i == LAST_V) stepped = '0;
    else                 stepped = cur_i + ONE_V;
  end

  always_comb begin
    unique case (op_i)
      OP_LOAD: nxt_o = din_i;
      OP_STEP: nxt_o = stepped;
      default: nxt_o = cur_i;
    endcase
  end

endmodule

// File: rtl/bcd_ctr_state.sv
module bcd_ctr_state #(
  parameter int DIG_W = 4
) (
  input  logic             clk_i,
  input  logic             clr_n_i,
  input  logic [DIG_W-1:0] nxt_i,
  output logic [DIG_W-1:0] cur_o
);

  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) cur_o <= '0;
    else          cur_o <= nxt_i;
  end

endmodule

// File: rtl/bcd_ctr_term.sv
module bcd_ctr_term #(
  parameter int DIG_W    = 4,
  parameter int LAST_VAL = 9
) (
  input  logic             chain_en_i,
  input  logic [DIG_W-1:0] cur_i,
  output logic             term_o
);

  localparam logic [DIG_W-1:0] LAST_V = DIG_W'(LAST_VAL);

  // Look-ahead flag: no register, so it follows the chain enable directly
  assign term_o = chain_en_i && (cur_i == LAST_V);

endmodule

// File: rtl/bcd_decade_ctr.sv
module bcd_decade_ctr
  import bcd_ctr_pkg::*;
#(
  parameter int DIG_W    = 4,
  parameter int LAST_VAL = 9
) (
  input  logic             clk_i,
  input  logic             clr_n_i,
  input  logic             load_n_i,
  input  logic [DIG_W-1:0] din_i,
  input  logic             cnt_en_i,
  input  logic             chain_en_i,
  output logic [DIG_W-1:0] count_o,
  output logic             term_o
);

  ctr_op_e          op;
  logic [DIG_W-1:0] nxt;
  logic [DIG_W-1:0] cur;

  bcd_ctr_ctrl u_ctrl (
    .load_n_i   (load_n_i),
    .cnt_en_i   (cnt_en_i),
    .chain_en_i (chain_en_i),
    .op_o       (op)
  );

  bcd_ctr_next #(.DIG_W(DIG_W), .LAST_VAL(LAST_VAL)) u_next (
    .op_i  (op),
    .cur_i (cur),
    .din_i (din_i),
    .nxt_o (nxt)
  );

  bcd_ctr_state #(.DIG_W(DIG_W)) u_state (
    .clk_i   (clk_i),
    .clr_n_i (clr_n_i),
    .nxt_i   (nxt),
    .cur_o   (cur)
  );

  bcd_ctr_term #(.DIG_W(DIG_W), .LAST_VAL(LAST_VAL)) u_term (
    .chain_en_i (chain_en_i),
    .cur_i      (cur),
    .term_o     (term_o)
  );

  assign count_o = cur;

endmodule

// File: rtl/bcd_decade_ctr_chk.sv
module bcd_decade_ctr_chk #(
  parameter int DIG_W    = 4,
  parameter int LAST_VAL = 9
) (
  input logic             clk_i,
  input logic             clr_n_i,
  input logic             load_n_i,
  input logic [DIG_W-1:0] din_i,
  input logic             cnt_en_i,
  input logic             chain_en_i,
  input logic [DIG_W-1:0] count_o,
  input logic             term_o
);

  localparam logic [DIG_W-1:0] LAST_V = DIG_W'(LAST_VAL);
  localparam logic [DIG_W-1:0] ONE_V  = DIG_W'(1);

  // Set once clear was high at an edge; any clear pulse drops it again
  logic             armed;
  logic [DIG_W-1:0] step_exp;

  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  always_comb begin
    if (count_o == LAST_V) step_exp = '0;
    else                   step_exp = count_o + ONE_V;
  end

  AST_STEP_SEQUENCE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (armed && $past(load_n_i && cnt_en_i && chain_en_i)) |-> (count_o == $past(step_exp))); // R1

  AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk_i)
    (clr_n_i === 1'b0) |-> (count_o == '0)); // R2

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (armed && $past(!load_n_i)) |-> (count_o == $past(din_i))); // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (armed && $past(load_n_i && !(cnt_en_i && chain_en_i))) |-> $stable(count_o)); // R4

  AST_TERM_NEEDS_NINE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    term_o |-> (chain_en_i && count_o == LAST_V)); // R5

  AST_TERM_AT_NINE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (chain_en_i && count_o == LAST_V) |-> term_o); // R5

endmodule

bind bcd_decade_ctr bcd_decade_ctr_chk #(.DIG_W(DIG_W), .LAST_VAL(LAST_VAL)) u_chk (
  .clk_i      (clk_i),
  .clr_n_i    (clr_n_i),
  .load_n_i   (load_n_i),
  .din_i      (din_i),
  .cnt_en_i   (cnt_en_i),
  .chain_en_i (chain_en_i),
  .count_o    (count_o),
  .term_o     (term_o)
);

// File: tb/bcd_decade_ctr_tb_top.sv
`timescale 1ns/1ps
module bcd_decade_ctr_tb_top;

  logic       clk = 1'b0;
  logic       clr_n;
  logic       load_n;
  logic [3:0] din;
  logic       en;
  logic       chain;
  logic [3:0] cnt;
  logic       term;

  // Three-stage chain; shares the clock and the clear with the single DUT
  logic       c_en;
  logic       c_load_n;
  logic [3:0] c_q [3];
  logic       c_t [3];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_decade_ctr dut_i (
    .clk_i (clk), .clr_n_i (clr_n), .load_n_i (load_n), .din_i (din),
    .cnt_en_i (en), .chain_en_i (chain), .count_o (cnt), .term_o (term)
  );

  bcd_decade_ctr u_casc0 (
    .clk_i (clk), .clr_n_i (clr_n), .load_n_i (c_load_n), .din_i (4'd0),
    .cnt_en_i (c_en), .chain_en_i (1'b1), .count_o (c_q[0]), .term_o (c_t[0])
  );
  bcd_decade_ctr u_casc1 (
    .clk_i (clk), .clr_n_i (clr_n), .load_n_i (c_load_n), .din_i (4'd0),
    .cnt_en_i (c_en), .chain_en_i (c_t[0]), .count_o (c_q[1]), .term_o (c_t[1])
  );
  bcd_decade_ctr u_casc2 (
    .clk_i (clk), .clr_n_i (clr_n), .load_n_i (c_load_n), .din_i (4'd0),
    .cnt_en_i (c_en), .chain_en_i (c_t[1]), .count_o (c_q[2]), .term_o (c_t[2])
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One rising edge, then settle 1 ns past it for driving and sampling
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    clr_n = 1'b0; load_n = 1'b1; din = 4'd0; en = 1'b0; chain = 1'b0;
    c_en = 1'b0; c_load_n = 1'b1;
    tick(); tick();
    check(cnt == 4'd0, "R2 reset value", cnt, 0);
    check(term == 1'b0, "R5 term after reset", term, 0);
    clr_n = 1'b1;
    tick();
    check(cnt == 4'd0, "R4 idle after reset", cnt, 0);
  endtask

  task automatic t_count_wrap();
    load_n = 1'b1; en = 1'b1; chain = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      check(cnt == 4'(i % 10), "R1 step/wrap", cnt, i % 10);
    end
    en = 1'b0; chain = 1'b0;
  endtask

  task automatic t_load();
    // Load under every enable combination
    for (int k = 0; k < 4; k++) begin
      en = k[0]; chain = k[1]; load_n = 1'b0; din = 4'(3 + 2 * k);
      tick();
      check(cnt == 4'(3 + 2 * k), "R3 load ignores enables", cnt, 3 + 2 * k);
    end
    load_n = 1'b1; en = 1'b0; chain = 1'b0;
  endtask

  task automatic t_hold();
    load_n = 1'b0; din = 4'd6; tick(); load_n = 1'b1;
    din = 4'd1;
    for (int k = 0; k < 3; k++) begin
      en = (k == 1); chain = (k == 2);
      tick(); tick();
      check(cnt == 4'd6, "R4 hold with an enable low", cnt, 6);
    end
    en = 1'b0; chain = 1'b0;
  endtask

  task automatic t_term();
    load_n = 1'b0; din = 4'd9; en = 1'b0; chain = 1'b0; tick(); load_n = 1'b1;
    check(term == 1'b0, "R5 term gated by chain", term, 0);
    chain = 1'b1; #1;
    check(term == 1'b1, "R5 term follows chain without clock", term, 1);
    en = 1'b1; #1;
    check(term == 1'b1, "R5 shared enable no effect", term, 1);
    tick();
    check(cnt == 4'd0 && term == 1'b0, "R5 term drops after wrap", {cnt, term}, 0);
    chain = 1'b0; #1;
    check(term == 1'b0, "R5 term low off nine", term, 0);
    load_n = 1'b0; din = 4'd8; en = 1'b0; tick(); load_n = 1'b1;
    chain = 1'b1; #1;
    check(term == 1'b0, "R5 term low at eight", term, 0);
    en = 1'b0; chain = 1'b0;
  endtask

  task automatic t_invalid();
    load_n = 1'b0; din = 4'd10; tick(); load_n = 1'b1;
    en = 1'b1; chain = 1'b1;
    for (int i = 11; i <= 17; i++) begin
      tick();
      check(cnt == 4'(i % 16), "R6 out-of-range recovery", cnt, i % 16);
    end
    en = 1'b0; chain = 1'b0;
  endtask

  task automatic t_async_clear();
    load_n = 1'b0; din = 4'd7; tick(); load_n = 1'b1;
    check(cnt == 4'd7, "R3 preload before clear", cnt, 7);
    clr_n = 1'b0; #1;
    check(cnt == 4'd0, "R2 clear without clock", cnt, 0);
    load_n = 1'b0; din = 4'd5; en = 1'b1; chain = 1'b1;
    tick();
    check(cnt == 4'd0, "R2 clear overrides load and enables", cnt, 0);
    load_n = 1'b1;
    clr_n = 1'b1;
    tick();
    check(cnt == 4'd1, "R1 count resumes after clear", cnt, 1);
    en = 1'b0; chain = 1'b0;
  endtask

  task automatic t_cascade();
    int ref_val = 0;
    int got;
    c_load_n = 1'b1;
    for (int n = 0; n < 1010; n++) begin
      c_en = (n % 97 != 50);
      tick();
      if (c_en) ref_val = (ref_val + 1) % 1000;
      got = 100 * int'(c_q[2]) + 10 * int'(c_q[1]) + int'(c_q[0]);
      check(got == ref_val, "R7 three-digit count", got, ref_val);
      if (ref_val == 999)
        check(c_t[2] == 1'b1, "R7 top terminal at 999", c_t[2], 1);
    end
    c_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_count_wrap();
    t_load();
    t_hold();
    t_term();
    t_invalid();
    t_async_clear();
    t_cascade();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule